// File: doc/BRIEF.md
# Stereo Codec Playback Streamer

This block holds a ring of stereo sample words in on-chip RAM and plays them out to an audio codec over a three-wire serial link. It makes the codec's master clock, its bit clock and its channel-select (frame) clock from the system clock, then shifts one stored word per frame onto the serial data line. Each word carries the left channel in its upper half and the right channel in its lower half.

The RAM is used as two halves in ping-pong fashion. A producer fills the RAM through a plain write port. Whenever the streamer has fetched the last entry of one half, it raises a one-cycle interrupt so the producer can refill that half while the other half plays. A sticky underrun flag shows that the streamer started on a half that was never rewritten after it was handed back.

Top module: `codec_stream_tx`

## Requirements
- R1: While reset is asserted (`rst_n` low, synchronous), `mclk` and `bclk` are 0, `lrck` is 1, and `sdata`, `irq` and `underrun` are 0.
- R2: `mclk` has a period of 2*MCLK_HALF system clocks. `bclk` has a period of 256/(2*CH_W) `mclk` periods. One `lrck` period (a frame) is 2*CH_W `bclk` periods, which is 256 `mclk` periods.
- R3: `lrck` is 1 during the first CH_W bit slots of a frame (left channel) and 0 during the last CH_W slots (right channel). It only changes on a falling edge of `bclk`.
- R4: `sdata` changes only on a falling edge of `bclk` and is steady while `bclk` is high. A word is sent most significant bit first, with bits [2*CH_W-1:CH_W] as left and bits [CH_W-1:0] as right.
- R5: Entries are fetched one per frame in ascending address order, wrapping from DEPTH-1 to 0. The frame that follows reset is silent (all zero). Entry 0 plays in the second frame.
- R6: `irq` is a single-cycle pulse, raised the cycle after the fetch of entry DEPTH/2-1 or entry DEPTH-1. Pulses are therefore DEPTH/2 frames apart, and they alternate between the lower half and the upper half.
- R7: A write with `wr_en` high stores `wr_data` at `wr_addr` on that clock edge. Data written into a half after its interrupt is what plays on the next pass through that half.
- R8: `underrun` becomes 1 when the first entry of a half is fetched and no write has landed in that half since its last interrupt (or since reset). It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe of the producer port |
| wr_addr | input | $clog2(DEPTH) | RAM entry to write |
| wr_data | input | 2*CH_W | Stereo word, left in the upper half |
| mclk | output | 1 | Codec master clock, 256 times the frame rate |
| bclk | output | 1 | Codec bit clock |
| lrck | output | 1 | Channel select: 1 for left, 0 for right |
| sdata | output | 1 | Serial sample data to the codec |
| irq | output | 1 | One-cycle pulse when a half has been consumed |
| underrun | output | 1 | Sticky flag: a stale half began to play |

## Verification
The serial stream is decoded at the ports and compared word by word against words computed in the bench. Four word shapes rotate through the stream: extreme values of opposite sign in the two channels, a single walking one, a single walking zero, and arithmetic mixes. The walking patterns expose any swapped, dropped or shifted bit position, and the extreme values expose a channel swap or a bit-order reversal. The RAM is refilled on every interrupt for several passes around the ring, which separates correct ping-pong ordering from stale or misaddressed playback. After that, refills are withheld, to tell a correctly timed underrun from one that fires too early or clears itself.

// File: rtl/codec_stream_pkg.sv
package codec_stream_pkg;

  // master clock cycles per frame, fixed by the codec format
  localparam int unsigned MCLK_PER_FS = 256;

  // master-clock half periods in one frame
  function automatic int unsigned halves_per_frame();
    return 2 * MCLK_PER_FS;
  endfunction

  // master-clock half periods per bit slot (one full bclk period)
  function automatic int unsigned halves_per_slot(int unsigned ch_w);
    return halves_per_frame() / (2 * ch_w);
  endfunction

endpackage

// File: rtl/codec_clk_gen.sv
module codec_clk_gen
  import codec_stream_pkg::*;
#(
  parameter int unsigned CH_W      = 16,
  parameter int unsigned MCLK_HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic mclk,
  output logic bclk,
  output logic lrck,
  output logic slot_end,
  output logic frame_end
);
  localparam int unsigned HPF  = halves_per_frame();
  localparam int unsigned HW   = $clog2(HPF);
  localparam int unsigned HPS  = halves_per_slot(CH_W);
  localparam int unsigned SLW  = $clog2(HPS);

  logic          adv;
  logic [HW-1:0] hcnt;

  generate
    if (MCLK_HALF == 1) begin : g_nopre
      assign adv = 1'b1;
    end else begin : g_pre
      localparam int unsigned PW = $clog2(MCLK_HALF);
      localparam logic [PW-1:0] PLAST = PW'(MCLK_HALF - 1);
      logic [PW-1:0] pre;
      always_ff @(posedge clk) begin
        if (!rst_n)          pre <= '0;
        else if (pre == PLAST) pre <= '0;
        else                 pre <= pre + 1'b1;
      end
      assign adv = (pre == PLAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)   hcnt <= '0;
    else if (adv) hcnt <= hcnt + 1'b1;
  end

  logic slot_last, frame_last;
  assign slot_last  = &hcnt[SLW-1:0];
  assign frame_last = &hcnt;

  assign mclk      = hcnt[0];
  assign bclk      = hcnt[SLW-1];
  assign lrck      = ~hcnt[HW-1];
  assign slot_end  = adv & slot_last & ~frame_last;
  assign frame_end = adv & frame_last;

  // R3: channel select moves only with a falling bit clock
  assert_lrck_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrck) |-> $fell(bclk));

  // R2: master clock toggles on every advance step
  assert_mclk_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !$stable(mclk));

endmodule

// File: rtl/codec_sample_ram.sv
module codec_sample_ram #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W     = 32
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [W-1:0]             wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [W-1:0]             rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/codec_serializer.sv
module codec_serializer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         frame_end,
  input  logic         slot_end,
  input  logic [W-1:0] load_word,
  output logic         sdata
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n)         sreg <= '0;
    else if (frame_end) sreg <= load_word;
    else if (slot_end)  sreg <= {sreg[W-2:0], 1'b0};
  end

  assign sdata = sreg[W-1];

  // R4: data line only moves together with a falling bit clock
  assert_sdata_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $fell(bclk));

endmodule

// File: rtl/codec_pingpong.sv
module codec_pingpong #(
  parameter int unsigned DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_end,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic                     irq,
  output logic                     underrun
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic       release_ev;
  logic       start_ev;
  logic       cur_half;
  logic [1:0] fresh;

  assign cur_half   = rd_ptr[AW-1];
  assign release_ev = frame_end & (&rd_ptr[AW-2:0]);
  assign start_ev   = frame_end & ~(|rd_ptr[AW-2:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= release_ev;
      if (frame_end) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < 2; i++) begin : g_half
      logic nxt;
      always_comb begin
        nxt = fresh[i];
        if (release_ev && (cur_half == 1'(i))) nxt = 1'b0;
        if (wr_en && (wr_addr[AW-1] == 1'(i)))  nxt = 1'b1;
      end
      always_ff @(posedge clk) begin
        if (!rst_n) fresh[i] <= 1'b0;
        else        fresh[i] <= nxt;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                           underrun <= 1'b0;
    else if (start_ev && !fresh[cur_half]) underrun <= 1'b1;
  end

  // R5: pointer wraps from the last entry back to zero
  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && (&rd_ptr)) |=> (rd_ptr == '0));

  // R6: interrupt is a single-cycle pulse following a fetch
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(frame_end));

  // R8: underrun is sticky and only rises on a fetch
  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  assert_underrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(frame_end));

endmodule

// File: rtl/codec_stream_tx.sv
module codec_stream_tx
  import codec_stream_pkg::*;
#(
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned CH_W      = 16,
  parameter int unsigned MCLK_HALF = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [2*CH_W-1:0]        wr_data,
  output logic                     mclk,
  output logic                     bclk,
  output logic                     lrck,
  output logic                     sdata,
  output logic                     irq,
  output logic                     underrun
);
  localparam int unsigned W  = 2 * CH_W;
  localparam int unsigned AW = $clog2(DEPTH);

  logic          slot_end, frame_end;
  logic [AW-1:0] rd_ptr;
  logic [W-1:0]  rd_word;

  codec_clk_gen #(.CH_W(CH_W), .MCLK_HALF(MCLK_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .mclk(mclk), .bclk(bclk), .lrck(lrck),
    .slot_end(slot_end), .frame_end(frame_end)
  );

  codec_sample_ram #(.DEPTH(DEPTH), .W(W)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_ptr), .rd_data(rd_word)
  );

  codec_serializer #(.W(W)) u_ser (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .frame_end(frame_end),
    .slot_end(slot_end), .load_word(rd_word), .sdata(sdata)
  );

  codec_pingpong #(.DEPTH(DEPTH)) u_pp (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .wr_en(wr_en),
    .wr_addr(wr_addr), .rd_ptr(rd_ptr), .irq(irq), .underrun(underrun)
  );

endmodule

// File: tb/tb_codec_stream_tx.sv
module tb_codec_stream_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int HALF       = DEPTH / 2;
  localparam int CH_W       = 16;
  localparam int FRAME_CYC  = 512;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic mclk, bclk, lrck, sdata, irq, underrun;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_stream_tx #(.DEPTH(DEPTH), .CH_W(CH_W), .MCLK_HALF(1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mclk(mclk), .bclk(bclk), .lrck(lrck),
    .sdata(sdata), .irq(irq), .underrun(underrun)
  );

  function automatic logic [31:0] word_of(int k);
    case (k % 4)
      0: return 32'h8000_7FFF ^ (32'(k) << 4);
      1: return 32'h1 << (k % 32);
      2: return ~(32'h1 << (k % 32));
      default: return {16'(k * 977), 16'(k * 313 + 5)};
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // serial stream decoder, samples at negedge
  logic [31:0] rx [0:127];
  int rx_cnt = 0;
  int lr_err = 0;
  int sd_err = 0;
  logic prev_bclk = 0, prev_sd = 0, lr_at_bit = 1;
  bit armed = 0;
  int bitn = 0;
  logic [31:0] acc = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_bclk && bclk && (sdata !== prev_sd)) sd_err++;
      if (!prev_bclk && bclk) begin
        if (lrck && !lr_at_bit) begin armed = 1; bitn = 0; end
        lr_at_bit = lrck;
        if (armed) begin
          if (lrck !== (bitn < CH_W)) lr_err++;
          acc = {acc[30:0], sdata};
          bitn++;
          if (bitn == 32) begin
            if (rx_cnt < 128) rx[rx_cnt] = acc;
            rx_cnt++;
            armed = 0;
          end
        end
      end
      prev_bclk = bclk;
      prev_sd = sdata;
    end
  end

  task automatic write_word(int addr, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic test_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(mclk == 0, "R1", "mclk in reset", 32'(mclk), 0);
    chk(bclk == 0, "R1", "bclk in reset", 32'(bclk), 0);
    chk(lrck == 1, "R1", "lrck in reset", 32'(lrck), 1);
    chk(sdata == 0, "R1", "sdata in reset", 32'(sdata), 0);
    chk(irq == 0, "R1", "irq in reset", 32'(irq), 0);
    chk(underrun == 0, "R1", "underrun in reset", 32'(underrun), 0);
    rst_n = 1;
  endtask

  // R7: prefill both halves with round 0
  task automatic test_prefill();
    for (int e = 0; e < DEPTH; e++) write_word(e, word_of(e));
  endtask

  // R2: clock ratios over one frame
  task automatic test_ratios();
    int m = 0, b = 0, c = 0;
    logic pm, pb, pl;
    pl = lrck;
    while (!(lrck && !pl)) begin pl = lrck; @(negedge clk); end
    pm = mclk; pb = bclk; pl = lrck;
    do begin
      @(negedge clk);
      c++;
      if (mclk && !pm) m++;
      if (bclk && !pb) b++;
      pm = mclk; pb = bclk;
      if (lrck && !pl) break;
      pl = lrck;
    end while (c < 2000);
    chk(c == FRAME_CYC, "R2", "cycles per frame", 32'(c), FRAME_CYC);
    chk(m == 256, "R2", "mclk per frame", 32'(m), 256);
    chk(b == 32, "R2", "bclk per frame", 32'(b), 32);
  endtask

  int last_irq_t = -1;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic wait_irq(int idx);
    int t = 0;
    while (!irq && t < 20000) begin @(negedge clk); t++; end
    chk(irq == 1, "R6", "irq seen", 32'(irq), 1);
    if (last_irq_t >= 0)
      chk(cyc - last_irq_t == HALF * FRAME_CYC, "R6", "irq spacing",
          32'(cyc - last_irq_t), HALF * FRAME_CYC);
    last_irq_t = cyc;
    @(negedge clk);
    chk(irq == 0, "R6", "irq one cycle", 32'(irq), 0);
    if (idx < 0) return;
  endtask

  // R6 R7 R8: refill on each interrupt, halves alternate
  task automatic test_refill(int rounds);
    for (int i = 0; i < rounds; i++) begin
      wait_irq(i);
      chk(underrun == 0, "R8", "no underrun while refilled", 32'(underrun), 0);
      for (int e = 0; e < HALF; e++)
        write_word((i % 2) * HALF + e, word_of(DEPTH + HALF * i + e));
    end
  endtask

  // R4 R5 R7: decoded words match, in order with wrap
  task automatic test_stream();
    int n;
    n = (rx_cnt < 56) ? rx_cnt : 56;
    chk(rx_cnt >= 40, "R5", "frames decoded", 32'(rx_cnt), 40);
    for (int k = 0; k < n; k++)
      chk(rx[k] == word_of(k), "R5", $sformatf("word %0d", k), rx[k], word_of(k));
    chk(lr_err == 0, "R3", "lrck vs slot", 32'(lr_err), 0);
    chk(sd_err == 0, "R4", "sdata moved with bclk high", 32'(sd_err), 0);
  endtask

  // R8: stale half raises sticky underrun
  task automatic test_underrun();
    wait_irq(0);
    wait_irq(1);
    chk(underrun == 0, "R8", "before stale fetch", 32'(underrun), 0);
    repeat (FRAME_CYC + 40) @(negedge clk);
    chk(underrun == 1, "R8", "after stale fetch", 32'(underrun), 1);
    for (int e = 0; e < DEPTH; e++) write_word(e, word_of(e));
    repeat (2 * FRAME_CYC) @(negedge clk);
    chk(underrun == 1, "R8", "sticky after refill", 32'(underrun), 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    test_reset();
    test_prefill();
    test_ratios();
    test_refill(6);
    test_stream();
    test_underrun();
    finish_run();
  end

endmodule